// File: doc/BRIEF.md
# Pointer Masking Mode Configuration Selector

This block holds the per-privilege-mode pointer masking settings of a 64-bit hart and picks, for each memory access, the setting that applies to it. There are five 2-bit fields. One controls machine mode. One controls supervisor/hypervisor mode. One controls virtual-supervisor mode. One controls user and virtual-user mode. The fifth applies only to hypervisor load/store instructions that are issued from non-virtualized user mode and act as virtual-user. Each field belongs to the configuration register of the mode one level above the mode it controls. The surrounding CSR file drives a write strobe and write data for each field and reads each field back.

The choice of field depends only on the effective privilege of the access. That privilege comes from the current mode, the virtualization bit, the machine modify-privilege controls (previous mode and previous virtualization) and the hypervisor load/store flag with its supervisor-privilege selector. The address value plays no part. The selected setting is registered together with the access request, so a later mode change cannot reach an access that is already in flight. Each field is WARL. The reserved code is refused. Any write is refused while the controlled mode runs with 32-bit XLEN. Narrowing that mode's XLEN clears the field for good.

Top module: `pm_cfg_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every field reads 00, `pm_valid` is 0 and `pm_setting` is 00.
- R2: A write of 00, 10 or 11 to field i (field index: 0 machine, 1 supervisor/hypervisor, 2 virtual supervisor, 3 user, 4 hypervisor user override) while `tgt_xlen32[i]` is 0 is visible on `fld_rdata[2i+1:2i]` on the next cycle.
- R3: A write of the reserved code 01 leaves the field at its previous value.
- R4: While `tgt_xlen32[i]` is 1, writes to field i are dropped and the field reads 00.
- R5: A field cleared by a narrowed XLEN still reads 00 after `tgt_xlen32[i]` returns to 0, until software writes it again.
- R6: Without modify-privilege and without a hypervisor load/store, the setting comes from field 0 for `priv`=11 (or 10), field 1 for `priv`=01 with `virt`=0, field 2 for `priv`=01 with `virt`=1, and field 3 for `priv`=00 with either `virt` value.
- R7: With `priv`=11 and `mprv`=1 (no hypervisor load/store), the effective mode is `mpp`, and it is virtual when `mpv`=1 and `mpp` is not 11. R6's mapping is then applied to that mode.
- R8: With `hlsv`=1 the access is virtual, with supervisor privilege when `spvp`=1 (field 2) and user privilege when `spvp`=0. The user case uses field 4 when issued from `priv`=00 with `virt`=0, and field 3 otherwise.
- R9: `pm_valid` follows `acc_valid` by one cycle. `pm_setting` takes the selected field value as it stood before any same-cycle write, and holds while `acc_valid` is 0.
- R10: With parameter `SUPPORTED`=0, every field and `pm_setting` read 00 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_we | input | 5 | Write strobe per field |
| fld_wdata | input | 10 | Write data, 2 bits per field, field i at [2i+1:2i] |
| tgt_xlen32 | input | 5 | Per field: controlled mode runs with 32-bit XLEN |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| virt | input | 1 | Current virtualization bit |
| mprv | input | 1 | Machine modify-privilege enable |
| mpp | input | 2 | Machine previous privilege |
| mpv | input | 1 | Machine previous virtualization |
| hlsv | input | 1 | Access is a hypervisor load/store |
| spvp | input | 1 | Hypervisor load/store privilege (1 supervisor, 0 user) |
| acc_valid | input | 1 | Access request this cycle |
| fld_rdata | output | 10 | Read-back of all fields, field i at [2i+1:2i] |
| pm_valid | output | 1 | Registered access valid |
| pm_setting | output | 2 | Registered masking setting (00 off, 10 sign-extend from bit 56, 11 from bit 47) |

## Verification
The hardest case to reach from the ports is the override field. It applies only when a hypervisor load/store with user privilege is issued from non-virtualized user mode. A user-mode load/store from a virtual guest and a supervisor-issued one must still resolve to the plain user field. The stimulus first loads the user field and the override field with different codes. It then drives each issuing context in turn and holds the rest of the mode inputs steady. A long random phase follows, in which XLEN narrowing, reserved writes and mode changes overlap with accesses. A behavioural model checks every cycle of it.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

  localparam int PM_W       = 2;
  localparam int NUM_FIELDS = 5;

  localparam int FLD_M  = 0;
  localparam int FLD_S  = 1;
  localparam int FLD_VS = 2;
  localparam int FLD_U  = 3;
  localparam int FLD_HU = 4;

  typedef enum logic [PM_W-1:0] {
    PM_OFF   = 2'b00,
    PM_RSVD  = 2'b01,
    PM_LEN7  = 2'b10,
    PM_LEN16 = 2'b11
  } pm_code_e;

  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;

  function automatic logic pm_code_legal(input logic [PM_W-1:0] code);
    return code != PM_RSVD;
  endfunction

endpackage

// File: rtl/pm_field.sv
module pm_field
  import pm_cfg_pkg::*;
#(
  parameter bit SUPPORTED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PM_W-1:0] wdata,
  input  logic            narrow,
  output logic [PM_W-1:0] rdata
);

  generate
    if (SUPPORTED) begin : g_rw
      logic [PM_W-1:0] val_q;

      // Narrowing wins over a write; illegal codes are dropped.
      always_ff @(posedge clk) begin
        if (rst) begin
          val_q <= PM_OFF;
        end else if (narrow) begin
          val_q <= PM_OFF;
        end else if (we && pm_code_legal(wdata)) begin
          val_q <= wdata;
        end
      end

      assign rdata = val_q;
    end else begin : g_ro
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, we, wdata, narrow};
      assign rdata = PM_OFF;
    end
  endgenerate

endmodule

// File: rtl/pm_eff_mode.sv
module pm_eff_mode
  import pm_cfg_pkg::*;
(
  input  logic       [1:0] priv,
  input  logic             virt,
  input  logic             mprv,
  input  logic       [1:0] mpp,
  input  logic             mpv,
  input  logic             hlsv,
  input  logic             spvp,
  output logic [NUM_FIELDS-1:0] fld_sel
);

  logic [1:0] eff_priv;
  logic       eff_virt;
  logic       from_user;

  always_comb begin
    from_user = 1'b0;
    if (hlsv) begin
      eff_priv  = spvp ? PRV_S : PRV_U;
      eff_virt  = 1'b1;
      from_user = (priv == PRV_U) && !virt;
    end else if ((priv == PRV_M) && mprv) begin
      eff_priv = mpp;
      eff_virt = mpv && (mpp != PRV_M);
    end else begin
      eff_priv = priv;
      eff_virt = virt;
    end
  end

  // One-hot field select
  always_comb begin
    fld_sel = '0;
    unique case (eff_priv)
      PRV_S:   fld_sel[eff_virt ? FLD_VS : FLD_S] = 1'b1;
      PRV_U:   fld_sel[(eff_virt && from_user) ? FLD_HU : FLD_U] = 1'b1;
      default: fld_sel[FLD_M] = 1'b1;
    endcase
  end

endmodule

// File: rtl/pm_sel_reg.sv
module pm_sel_reg
  import pm_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FIELDS-1:0]      fld_sel,
  input  logic [NUM_FIELDS*PM_W-1:0] fld_vals,
  input  logic                       acc_valid,
  output logic                       pm_valid,
  output logic [PM_W-1:0]            pm_setting
);

  logic [NUM_FIELDS*PM_W-1:0] masked;
  logic [PM_W-1:0]            chosen;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_and
      assign masked[gi*PM_W +: PM_W] = fld_vals[gi*PM_W +: PM_W] & {PM_W{fld_sel[gi]}};
    end
  endgenerate

  always_comb begin
    chosen = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      chosen = chosen | masked[i*PM_W +: PM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_valid   <= 1'b0;
      pm_setting <= PM_OFF;
    end else begin
      pm_valid <= acc_valid;
      if (acc_valid) begin
        pm_setting <= chosen;
      end
    end
  end

endmodule

// File: rtl/pm_cfg_sel.sv
module pm_cfg_sel
  import pm_cfg_pkg::*;
#(
  parameter bit SUPPORTED = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FIELDS-1:0]      fld_we,
  input  logic [NUM_FIELDS*PM_W-1:0] fld_wdata,
  input  logic [NUM_FIELDS-1:0]      tgt_xlen32,
  input  logic [1:0]                 priv,
  input  logic                       virt,
  input  logic                       mprv,
  input  logic [1:0]                 mpp,
  input  logic                       mpv,
  input  logic                       hlsv,
  input  logic                       spvp,
  input  logic                       acc_valid,
  output logic [NUM_FIELDS*PM_W-1:0] fld_rdata,
  output logic                       pm_valid,
  output logic [PM_W-1:0]            pm_setting
);

  logic [NUM_FIELDS-1:0] fld_sel;

  genvar gf;
  generate
    for (gf = 0; gf < NUM_FIELDS; gf++) begin : g_fld
      pm_field #(.SUPPORTED(SUPPORTED)) u_fld (
        .clk    (clk),
        .rst    (rst),
        .we     (fld_we[gf]),
        .wdata  (fld_wdata[gf*PM_W +: PM_W]),
        .narrow (tgt_xlen32[gf]),
        .rdata  (fld_rdata[gf*PM_W +: PM_W])
      );
    end
  endgenerate

  pm_eff_mode u_eff (
    .priv    (priv),
    .virt    (virt),
    .mprv    (mprv),
    .mpp     (mpp),
    .mpv     (mpv),
    .hlsv    (hlsv),
    .spvp    (spvp),
    .fld_sel (fld_sel)
  );

  pm_sel_reg u_sel (
    .clk        (clk),
    .rst        (rst),
    .fld_sel    (fld_sel),
    .fld_vals   (fld_rdata),
    .acc_valid  (acc_valid),
    .pm_valid   (pm_valid),
    .pm_setting (pm_setting)
  );

endmodule

// File: rtl/pm_cfg_sel_chk.sv
module pm_cfg_sel_chk
  import pm_cfg_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_FIELDS-1:0]      fld_we,
  input logic [NUM_FIELDS*PM_W-1:0] fld_wdata,
  input logic [NUM_FIELDS-1:0]      tgt_xlen32,
  input logic [1:0]                 priv,
  input logic                       virt,
  input logic                       mprv,
  input logic                       hlsv,
  input logic                       spvp,
  input logic                       acc_valid,
  input logic [NUM_FIELDS*PM_W-1:0] fld_rdata,
  input logic                       pm_valid,
  input logic [PM_W-1:0]            pm_setting
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!pm_valid && pm_setting == PM_OFF)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> pm_valid); // R9

  AST_SETTING_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(pm_setting)); // R9

  AST_MACHINE_SEL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && priv == PRV_M && !mprv && !hlsv) |=> pm_setting == $past(fld_rdata[FLD_M*PM_W +: PM_W])); // R6

  AST_HU_SEL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && hlsv && !spvp && priv == PRV_U && !virt) |=> pm_setting == $past(fld_rdata[FLD_HU*PM_W +: PM_W])); // R8

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fa
      AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
        fld_rdata[gi*PM_W +: PM_W] != PM_RSVD); // R3

      AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (fld_we[gi] && fld_wdata[gi*PM_W +: PM_W] == PM_RSVD && !tgt_xlen32[gi])
        |=> $stable(fld_rdata[gi*PM_W +: PM_W])); // R3

      AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        tgt_xlen32[gi] |=> fld_rdata[gi*PM_W +: PM_W] == PM_OFF); // R4

      AST_NO_RESTORE: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_xlen32[gi]) |-> fld_rdata[gi*PM_W +: PM_W] == PM_OFF); // R5
    end
  endgenerate

endmodule

bind pm_cfg_sel pm_cfg_sel_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .fld_we     (fld_we),
  .fld_wdata  (fld_wdata),
  .tgt_xlen32 (tgt_xlen32),
  .priv       (priv),
  .virt       (virt),
  .mprv       (mprv),
  .hlsv       (hlsv),
  .spvp       (spvp),
  .acc_valid  (acc_valid),
  .fld_rdata  (fld_rdata),
  .pm_valid   (pm_valid),
  .pm_setting (pm_setting)
);

// File: tb/tb_pm_cfg_sel.sv
`timescale 1ns/1ps
module tb_pm_cfg_sel;

  localparam int NF = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] fld_we = '0;
  logic [2*NF-1:0] fld_wdata = '0;
  logic [NF-1:0] tgt_xlen32 = '0;
  logic [1:0]    priv = 2'b11;
  logic          virt = 1'b0, mprv = 1'b0, mpv = 1'b0, hlsv = 1'b0, spvp = 1'b0;
  logic [1:0]    mpp = 2'b00;
  logic          acc_valid = 1'b0;
  logic [2*NF-1:0] fld_rdata, ro_rdata;
  logic          pm_valid, ro_valid;
  logic [1:0]    pm_setting, ro_setting;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_cfg_sel dut (
    .clk(clk), .rst(rst), .fld_we(fld_we), .fld_wdata(fld_wdata), .tgt_xlen32(tgt_xlen32),
    .priv(priv), .virt(virt), .mprv(mprv), .mpp(mpp), .mpv(mpv), .hlsv(hlsv), .spvp(spvp),
    .acc_valid(acc_valid), .fld_rdata(fld_rdata), .pm_valid(pm_valid), .pm_setting(pm_setting));

  pm_cfg_sel #(.SUPPORTED(1'b0)) dut_ro (
    .clk(clk), .rst(rst), .fld_we(fld_we), .fld_wdata(fld_wdata), .tgt_xlen32(tgt_xlen32),
    .priv(priv), .virt(virt), .mprv(mprv), .mpp(mpp), .mpv(mpv), .hlsv(hlsv), .spvp(spvp),
    .acc_valid(acc_valid), .fld_rdata(ro_rdata), .pm_valid(ro_valid), .pm_setting(ro_setting));

  // Behavioural reference model
  int m_fld[NF];
  int m_set = 0;
  int m_vld = 0;

  function automatic int ref_field();
    int p, v;
    bit issued_user;
    issued_user = 1'b0;
    if (hlsv) begin
      v = 1;
      p = spvp ? 1 : 0;
      issued_user = (priv == 2'b00) && !virt;
    end else if (priv == 2'b11 && mprv) begin
      p = int'(mpp);
      v = (mpv && mpp != 2'b11) ? 1 : 0;
    end else begin
      p = int'(priv);
      v = int'(virt);
    end
    if (p >= 2) return 0;
    if (p == 1) return (v != 0) ? 2 : 1;
    return (v != 0 && issued_user) ? 4 : 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_fld[i]) m_fld[i] = 0;
      m_set = 0;
      m_vld = 0;
    end else begin
      int k;
      k = ref_field();
      if (acc_valid) m_set = m_fld[k];
      m_vld = int'(acc_valid);
      for (int i = 0; i < NF; i++) begin
        int wd;
        wd = int'(fld_wdata[2*i +: 2]);
        if (tgt_xlen32[i]) m_fld[i] = 0;
        else if (fld_we[i] && wd != 1) m_fld[i] = wd;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NF; i++)
        check(int'(fld_rdata[2*i +: 2]) == m_fld[i], cur_req, $sformatf("model field %0d", i),
              int'(fld_rdata[2*i +: 2]), m_fld[i]);
      check(int'(pm_valid) == m_vld, "R9", "model pm_valid", int'(pm_valid), m_vld);
      check(int'(pm_setting) == m_set, cur_req, "model pm_setting", int'(pm_setting), m_set);
      check(ro_rdata == '0 && ro_setting == 2'b00, "R10", "read-only variant",
            int'({ro_rdata, ro_setting}), 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [1:0] val);
    fld_we = '0;
    fld_we[idx] = 1'b1;
    fld_wdata[2*idx +: 2] = val;
    tick();
    fld_we = '0;
  endtask

  function automatic int fld(input int idx);
    return int'(fld_rdata[2*idx +: 2]);
  endfunction

  task automatic sel(input logic [1:0] p, input logic v, input logic mp, input logic [1:0] pp,
                     input logic pv, input logic h, input logic sp, input int exp, input string req);
    priv = p; virt = v; mprv = mp; mpp = pp; mpv = pv; hlsv = h; spvp = sp;
    acc_valid = 1'b1;
    tick();
    acc_valid = 1'b0;
    check(pm_valid == 1'b1, req, "valid after access", int'(pm_valid), 1);
    check(int'(pm_setting) == exp, req, "selected setting", int'(pm_setting), exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    cur_req = "R1";
    check(fld_rdata == '0, "R1", "fields in reset", int'(fld_rdata), 0);
    check(!pm_valid && pm_setting == 2'b00, "R1", "output in reset", int'({pm_valid, pm_setting}), 0);
    rst = 1'b0;
    tick();
    check(fld_rdata == '0 && !pm_valid, "R1", "first cycle after reset", int'(fld_rdata), 0);

    cur_req = "R2";
    wr(0, 2'b10); check(fld(0) == 2, "R2", "field 0 write 10", fld(0), 2);
    wr(1, 2'b11); check(fld(1) == 3, "R2", "field 1 write 11", fld(1), 3);
    wr(1, 2'b00); check(fld(1) == 0, "R2", "field 1 write 00", fld(1), 0);
    wr(4, 2'b11); check(fld(4) == 3, "R2", "field 4 write 11", fld(4), 3);

    cur_req = "R3";
    wr(4, 2'b01); check(fld(4) == 3, "R3", "reserved write kept", fld(4), 3);

    cur_req = "R4";
    tgt_xlen32[0] = 1'b1;
    tick();
    check(fld(0) == 0, "R4", "narrow clears field 0", fld(0), 0);
    wr(0, 2'b11); check(fld(0) == 0, "R4", "write while 32-bit", fld(0), 0);
    tgt_xlen32[0] = 1'b0;

    cur_req = "R5";
    wr(2, 2'b10);
    tgt_xlen32[2] = 1'b1; tick(); tgt_xlen32[2] = 1'b0; tick(); tick();
    check(fld(2) == 0, "R5", "value not restored", fld(2), 0);

    // Field setup: M=11, S=00, VS=10, U=00, HU=11
    cur_req = "R6";
    wr(0, 2'b11); wr(1, 2'b00); wr(2, 2'b10); wr(3, 2'b00); wr(4, 2'b11);
    sel(2'b11, 0, 0, 2'b00, 0, 0, 0, 3, "R6");
    sel(2'b01, 0, 0, 2'b00, 0, 0, 0, 0, "R6");
    sel(2'b01, 1, 0, 2'b00, 0, 0, 0, 2, "R6");
    sel(2'b00, 0, 0, 2'b00, 0, 0, 0, 0, "R6");
    sel(2'b00, 1, 0, 2'b00, 0, 0, 0, 0, "R6");

    cur_req = "R7";
    sel(2'b11, 0, 1, 2'b01, 0, 0, 0, 0, "R7");
    sel(2'b11, 0, 1, 2'b01, 1, 0, 0, 2, "R7");
    sel(2'b11, 0, 1, 2'b11, 1, 0, 0, 3, "R7");
    sel(2'b01, 0, 1, 2'b01, 1, 0, 0, 0, "R7");

    cur_req = "R8";
    sel(2'b00, 0, 0, 2'b00, 0, 1, 0, 3, "R8");
    sel(2'b01, 0, 0, 2'b00, 0, 1, 0, 0, "R8");
    sel(2'b00, 1, 0, 2'b00, 0, 1, 0, 0, "R8");
    sel(2'b01, 0, 0, 2'b00, 0, 1, 1, 2, "R8");

    cur_req = "R9";
    sel(2'b11, 0, 0, 2'b00, 0, 0, 0, 3, "R9");
    priv = 2'b01; tick();
    check(!pm_valid && pm_setting == 2'b11, "R9", "hold without access", int'(pm_setting), 3);
    priv = 2'b11; acc_valid = 1'b1;
    fld_we[0] = 1'b1; fld_wdata[1:0] = 2'b10;
    tick();
    fld_we = '0; acc_valid = 1'b0;
    check(pm_setting == 2'b11, "R9", "same-cycle write not seen", int'(pm_setting), 3);
    check(fld(0) == 2, "R9", "same-cycle write stored", fld(0), 2);

    cur_req = "R6/R7/R8 random";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] pv;
      pv = 2'($urandom_range(0, 3));
      priv = pv;
      virt = 1'($urandom);
      mprv = 1'($urandom);
      mpp = 2'($urandom);
      mpv = 1'($urandom);
      hlsv = ($urandom_range(0, 3) == 0);
      spvp = 1'($urandom);
      acc_valid = 1'($urandom);
      for (int i = 0; i < NF; i++) begin
        fld_we[i] = ($urandom_range(0, 3) == 0);
        fld_wdata[2*i +: 2] = 2'($urandom);
        tgt_xlen32[i] = ($urandom_range(0, 15) == 0);
      end
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule